// File: doc/BRIEF.md
# FSK Zero-Crossing Symbol Demodulator

This block turns a stream of unsigned ADC samples carrying a two-tone FSK subcarrier into a stream of raw symbol bits. It compares each accepted sample against a fixed level, which yields a one-bit square wave. It watches that square wave for low-to-high edges and counts the accepted samples between successive edges. Each measured period is then sorted into one of two classes with a single cut point. A short period (nominally 8 samples) gives symbol 1. A long period (nominally 10 samples) gives symbol 0. Periods jittered anywhere from 7 to 11 samples still fall into the correct class.

A sample enters on any clock where its valid strobe is high; clocks without the strobe leave all state untouched. One symbol comes out for each rising edge of the sliced signal, as a single-cycle valid pulse with the bit beside it. Later stages are expected to group these symbols into data bits.

Top module: `fsk_zc_demod`

## Requirements
- R1: A sample value below 127 slices to 0 and a value of 127 or more slices to 1.
- R2: A symbol is produced only for an accepted sample that slices to 1 when the previous accepted sample sliced to 0; steady levels and high-to-low steps produce none.
- R3: The period of a symbol is the count of accepted samples from the previous rising edge to the current one; clocks with `smp_valid` low neither advance that count nor change the slice history, whatever `smp_data` holds.
- R4: A period below 9 samples gives `sym_bit` = 1 and a period of 9 or more gives `sym_bit` = 0 (7 and 8 give 1; 9, 10 and 11 give 0).
- R5: The period counter saturates at 255 instead of wrapping, so any gap of 255 or more samples (including 256 and 264) gives `sym_bit` = 0.
- R6: `sym_valid` is high for exactly the one clock after the clock in which the edge sample was accepted, with `sym_bit` valid in that clock, and low in every other clock.
- R7: Synchronous active-high `rst` drives `sym_valid` low, clears the slice history and the counter; the first accepted sample after reset only seeds the history and never produces a symbol, and it counts as sample index 0 for the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; `smp_data` is taken when high |
| smp_data | input | 8 | Unsigned ADC sample |
| sym_valid | output | 1 | One-clock pulse marking a new symbol |
| sym_bit | output | 1 | Symbol value: 1 short period, 0 long period |

## Verification
Every symbol is due in the clock right after the clock that accepted its edge sample, since only the output register lies between the input and `sym_valid`. The bench applies each sample on the falling edge, lets the next rising edge take it, and one nanosecond later compares `sym_valid` (and `sym_bit` when a symbol is expected) with a behavioural model. The model tracks sample indices as plain integers. The comparison runs on every clock, including idle and reset clocks, so a late, early, doubled or missing pulse shows up in the clock where it happens.

// File: rtl/fsk_zc_pkg.sv
package fsk_zc_pkg;

  // Slice one sample against a level: 1 when at or above it.
  function automatic logic slice_bit(input int unsigned sample,
                                     input int unsigned level);
    return (sample >= level);
  endfunction

  // Period class: short periods map to symbol 1, long ones to symbol 0.
  function automatic logic period_class(input int unsigned period,
                                        input int unsigned cut);
    return (period < cut);
  endfunction

  // Increment that sticks at a ceiling.
  function automatic int unsigned sat_inc(input int unsigned value,
                                          input int unsigned ceiling);
    return (value >= ceiling) ? ceiling : value + 1;
  endfunction

endpackage

// File: rtl/fsk_edge_detect.sv
module fsk_edge_detect
  import fsk_zc_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int LEVEL = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             rise_take
);

  logic cur_slice;
  logic prev_slice;
  logic primed;

  assign cur_slice = slice_bit(32'(smp_data), 32'(LEVEL));
  assign rise_take = smp_valid && primed && !prev_slice && cur_slice;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_slice <= 1'b0;
      primed     <= 1'b0;
    end else if (smp_valid) begin
      prev_slice <= cur_slice;
      primed     <= 1'b1;
    end
  end

  // R7: the first accepted sample after reset never counts as an edge
  p_first_sample_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (!primed) |-> !rise_take);

  // R3: slice history frozen on idle clocks
  p_history_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid) |=> ($stable(prev_slice) && $stable(primed)));

endmodule

// File: rtl/fsk_period_count.sv
module fsk_period_count
  import fsk_zc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic             rise_take,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] period_next;

  // period holds (index of the sample being offered) - (index of last edge)
  assign period_next = CNT_W'(sat_inc(32'(period), 32'(CNT_MAX)));

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
    end else if (smp_valid) begin
      if (rise_take) period <= CNT_ONE;
      else           period <= period_next;
    end
  end

  // R5: a saturated count stays saturated until an edge
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !rise_take && period == CNT_MAX) |=> (period == CNT_MAX));

  // R3: one step per accepted sample below saturation
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !rise_take && period != CNT_MAX) |=> (period == $past(period) + CNT_ONE));

  // R3: an edge restarts the measurement
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    rise_take |=> (period == CNT_ONE));

  // R3: idle clocks leave the count alone
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid) |=> $stable(period));

endmodule

// File: rtl/fsk_symbol_reg.sv
module fsk_symbol_reg
  import fsk_zc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CUT   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_take,
  input  logic [CNT_W-1:0] period,
  output logic             sym_valid,
  output logic             sym_bit
);

  logic short_period;

  assign short_period = period_class(32'(period), 32'(CUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_valid <= 1'b0;
      sym_bit   <= 1'b0;
    end else begin
      sym_valid <= rise_take;
      if (rise_take) sym_bit <= short_period;
    end
  end

  // R6: bit is held between pulses
  p_bit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!rise_take) |=> $stable(sym_bit));

endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod
  import fsk_zc_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int LEVEL = 127,
  parameter int CUT   = 9,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             sym_valid,
  output logic             sym_bit
);

  logic             rise_take;
  logic [CNT_W-1:0] period;

  fsk_edge_detect #(.SMP_W(SMP_W), .LEVEL(LEVEL)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .rise_take (rise_take)
  );

  fsk_period_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .rise_take (rise_take),
    .period    (period)
  );

  fsk_symbol_reg #(.CNT_W(CNT_W), .CUT(CUT)) u_sym (
    .clk       (clk),
    .rst       (rst),
    .rise_take (rise_take),
    .period    (period),
    .sym_valid (sym_valid),
    .sym_bit   (sym_bit)
  );

  // R6: a symbol only follows an accepted sample
  p_valid_after_sample_r6: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> $past(smp_valid));

  // R2: the edge sample sliced high
  p_edge_sample_high_r2: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> (32'($past(smp_data)) >= 32'(LEVEL)));

  // R6: never two pulses in a row (an edge needs a low sample in between)
  p_no_double_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

endmodule

// File: tb/fsk_zc_demod_tb.sv
`timescale 1ns/1ps
module fsk_zc_demod_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'd0;
  wire        sym_valid;
  wire        sym_bit;

  int    n_chk = 0;
  int    n_fail = 0;
  string req = "R7";

  // behavioural model state
  int m_idx = 0;
  int m_last = 0;
  bit m_prev = 1'b0;
  bit m_primed = 1'b0;

  always #2 clk = ~clk;

  fsk_zc_demod u_dut (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .sym_valid (sym_valid),
    .sym_bit   (sym_bit)
  );

  task automatic check(input logic got, input bit exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (sample %0d)", req, what, got, exp, m_idx);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d);
    bit ev;
    bit eb;
    bit cur;
    ev = 1'b0;
    eb = 1'b0;
    @(negedge clk);
    smp_valid = v;
    smp_data  = d;
    if (v) begin
      cur = (d >= 8'd127);
      if (m_primed && !m_prev && cur) begin
        ev = 1'b1;
        eb = ((m_idx - m_last) < 9);
        m_last = m_idx;
      end
      m_prev = cur;
      m_primed = 1'b1;
      m_idx++;
    end
    @(posedge clk);
    #1;
    check(sym_valid, ev, "sym_valid");
    if (ev) check(sym_bit, eb, "sym_bit");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b1;
    smp_data = 8'd200;
    @(posedge clk);
    #1;
    req = "R7";
    check(sym_valid, 1'b0, "sym_valid in reset");
    m_idx = 0; m_last = 0; m_prev = 1'b0; m_primed = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    smp_valid = 1'b0;
  endtask

  // square wave: low half first, then high half, n periods of p samples
  task automatic wave(input int p, input int n, input logic [7:0] lo, input logic [7:0] hi);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < p; i++)
        step(1'b1, (i < p / 2) ? lo : hi);
  endtask

  task automatic low_run(input int len);
    for (int i = 0; i < len; i++) step(1'b1, 8'd10);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R7: first sample high gives nothing; edge at index 5 measured from index 0
    req = "R7";
    step(1'b1, 8'd220);
    low_run(4);
    step(1'b1, 8'd220);
    // R4: nominal periods and the jitter range
    req = "R4";
    wave(8, 6, 8'd30, 8'd230);
    wave(10, 6, 8'd30, 8'd230);
    wave(7, 4, 8'd30, 8'd230);
    wave(11, 4, 8'd30, 8'd230);
    wave(9, 4, 8'd30, 8'd230);
    for (int k = 0; k < 6; k++) begin
      wave(8, 1, 8'd40, 8'd210);
      wave(10, 1, 8'd40, 8'd210);
    end
    // R1: slicing exactly at the level boundary
    req = "R1";
    wave(8, 4, 8'd126, 8'd127);
    wave(10, 4, 8'd126, 8'd127);
    wave(8, 2, 8'd0, 8'd255);
    // R2: steady high and falling steps produce nothing
    req = "R2";
    for (int i = 0; i < 20; i++) step(1'b1, 8'd200);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 8'd200);
      step(1'b1, 8'd127);
    end
    low_run(3);
    step(1'b1, 8'd150);
    // R3: idle clocks with toggling data inside each period
    req = "R3";
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 10; i++) begin
        step(1'b1, (i < 5) ? 8'd20 : 8'd240);
        step(1'b0, (i[0]) ? 8'd0 : 8'd255);
      end
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++) begin
        step(1'b0, 8'd255);
        step(1'b1, (i < 4) ? 8'd20 : 8'd240);
        step(1'b0, 8'd0);
      end
    // R5: long gaps classify as long, never wrap
    req = "R5";
    step(1'b1, 8'd10);
    step(1'b1, 8'd200);
    low_run(299);
    step(1'b1, 8'd200);
    low_run(263);
    step(1'b1, 8'd200);
    low_run(255);
    step(1'b1, 8'd200);
    wave(8, 3, 8'd30, 8'd230);
    // R6: fastest edges, pulses every other clock
    req = "R6";
    wave(2, 10, 8'd0, 8'd255);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 8'd0);
      step(1'b0, 8'd0);
      step(1'b1, 8'd255);
    end
    // R7: reset mid-stream while the last sample was low
    step(1'b1, 8'd0);
    do_reset();
    req = "R7";
    step(1'b1, 8'd255);
    step(1'b1, 8'd0);
    step(1'b1, 8'd255);
    wave(10, 3, 8'd30, 8'd230);
    step(1'b0, 8'd0);
    step(1'b0, 8'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule